// File: doc/BRIEF.md
# Single-Dword PCIe Completer Bridge

This block sits behind the transaction layer of a PCIe endpoint that only ever acts as a completer. It takes memory read and memory write requests from a receive stream and serves them on a 32-bit memory-mapped master bus. A request is at most one dword. The bus address comes from masking the request address to a configurable aperture and adding a local base. A valid single-dword read turns into one bus read, and the returned data goes back as a completion on a transmit stream. A valid single-dword write turns into one bus write and gets no completion, because PCIe writes are posted.

Requests longer than one dword are refused without touching the bus. An oversized read is answered with a data-less completion whose status is Completer Abort. An oversized write has all of its data beats consumed and dropped, and nothing else happens. The bridge works on one request at a time. Receive ready stays low from the moment a request is accepted until the block is free again. For a read, that is after the completion has been handed over. For a write, it is after the bus has accepted the write.

On the receive stream, a request header and its first data dword arrive together in one beat, marked by `rx_sop`. Any further write data beats follow with `rx_sop` low.

Top module: `sdw_completer_bridge`

## Requirements
- R1: A header beat (`rx_sop`=1) with `rx_is_write`=0 and `rx_len_dw`=1 causes exactly one bus read. The completion that follows has `tx_status`=3'b000, `tx_has_data`=1, the read data in `tx_data`, and the request's requester ID and tag.
- R2: A read header with `rx_len_dw`≠1 causes no bus access. It gets one completion with `tx_status`=3'b100, `tx_has_data`=0, and the requester ID and tag echoed.
- R3: A write header with `rx_len_dw`≠1 causes no bus access and no completion. The block then accepts and drops `rx_len_dw`−1 further beats (length 0 means 1024 dwords) before it treats a beat as a new header.
- R4: At most one request is in flight, and `rx_ready` is low while the bus or the transmit stream is busy. After a read, the next header is accepted no earlier than the cycle after the completion handshake. After a single-dword write, the next header is accepted no earlier than the cycle after the bus accepts the write. `m_read` and `m_write` are never high together.
- R5: The bus address is `LOCAL_BASE + (rx_addr & (2^APER_BITS−1))`, with bits 1:0 cleared.
- R6: `rx_first_be` appears unchanged on `m_byteenable` for both reads and writes.
- R7: `tx_byte_count` follows the byte enables:
  - 1xx1 gives 4.
  - 01x1 and 1x10 give 3.
  - 0011, 0110 and 1100 give 2.
  - Any other pattern gives 1.

  `tx_lower_addr` is made of address bits 6:2 followed by the index of the lowest enabled byte, or 0 when no byte is enabled.
- R8: While `m_waitrequest` is high, the command, address and byte enables hold steady. Read data is taken from `m_readdata` in the cycle `m_readdatavalid` is high.
- R9: A write header with `rx_len_dw`=1 causes one bus write carrying `rx_data` and no completion.
- R10: A completion stays valid, with unchanged fields, until `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted when high with rx_valid |
| rx_sop | input | 1 | 1 = header beat, 0 = trailing data beat |
| rx_is_write | input | 1 | 1 = memory write, 0 = memory read |
| rx_len_dw | input | LEN_W | Request length in dwords (0 means 1024) |
| rx_addr | input | 32 | Request byte address |
| rx_first_be | input | 4 | First-dword byte enables |
| rx_req_id | input | 16 | Requester ID |
| rx_tag | input | 8 | Request tag |
| rx_data | input | 32 | First write data dword |
| tx_valid | output | 1 | Completion valid |
| tx_ready | input | 1 | Completion accepted when high with tx_valid |
| tx_status | output | 3 | 3'b000 successful, 3'b100 completer abort |
| tx_has_data | output | 1 | Completion carries one data dword |
| tx_req_id | output | 16 | Echoed requester ID |
| tx_tag | output | 8 | Echoed tag |
| tx_byte_count | output | 12 | Byte count |
| tx_lower_addr | output | 7 | Lower address |
| tx_data | output | 32 | Completion data |
| m_address | output | 32 | Bus byte address |
| m_byteenable | output | 4 | Bus byte enables |
| m_read | output | 1 | Bus read command |
| m_write | output | 1 | Bus write command |
| m_writedata | output | 32 | Bus write data |
| m_waitrequest | input | 1 | Bus stall |
| m_readdata | input | 32 | Bus read data |
| m_readdatavalid | input | 1 | Bus read data valid |

## Verification
Two events can land in the same clock cycle. One is the transmit handshake that retires a read. The other is a new request header already waiting on the receive stream. The bench provokes this by holding a second header valid while the first completion is stalled for several cycles by a delayed `tx_ready`. It then checks that the header is taken exactly one cycle after the completion handshake and never in the handshake cycle itself. The same check is made for a write: a header waits while the bus write is held off by `m_waitrequest`, and it must be accepted one cycle after the bus accepts the write.

// File: rtl/sdwb_pkg.sv
package sdwb_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;
    localparam int RID_W = 16;
    localparam int TAG_W = 8;
    localparam int BC_W  = 12;
    localparam int LA_W  = 7;
    localparam int LO_W  = 2;

    localparam logic [2:0] CPL_OK    = 3'b000;
    localparam logic [2:0] CPL_ABORT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_CPL,
        ST_WR_CMD,
        ST_DRAIN
    } state_e;

    // Captured request; data holds write data, later the read data
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [BEW-1:0]   be;
        logic [RID_W-1:0] rid;
        logic [TAG_W-1:0] tag;
        logic [DW-1:0]    data;
        logic             abort;
    } req_t;
endpackage

// File: rtl/sdwb_addr_map.sv
module sdwb_addr_map
    import sdwb_pkg::*;
#(
    parameter int              APER_BITS  = 16,
    parameter logic [AW-1:0]   LOCAL_BASE = 32'h4000_0000
) (
    input  logic [AW-1:0] pcie_addr,
    output logic [AW-1:0] bus_addr
);
    localparam logic [AW-1:0] APER_MASK = {AW{1'b1}} >> (AW - APER_BITS);
    localparam logic [AW-1:0] DW_ALIGN  = ~AW'(BEW - 1);

    always_comb begin
        bus_addr = LOCAL_BASE + (pcie_addr & APER_MASK & DW_ALIGN);
    end
endmodule

// File: rtl/sdwb_be_decode.sv
module sdwb_be_decode
    import sdwb_pkg::*;
(
    input  logic [BEW-1:0]     be,
    input  logic [LA_W-3:0]    addr_dw,
    output logic [BC_W-1:0]    byte_count,
    output logic [LA_W-1:0]    lower_addr
);
    logic [LO_W-1:0] lo;

    always_comb begin
        casez (be)
            4'b1??1:                   byte_count = BC_W'(4);
            4'b01?1, 4'b1?10:          byte_count = BC_W'(3);
            4'b0011, 4'b0110, 4'b1100: byte_count = BC_W'(2);
            default:                   byte_count = BC_W'(1);
        endcase
        lo = '0;
        for (int i = BEW - 1; i >= 0; i--) begin
            if (be[i]) lo = LO_W'(i);
        end
        lower_addr = {addr_dw, lo};
    end
endmodule

// File: rtl/sdwb_ctrl.sv
module sdwb_ctrl
    import sdwb_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             rx_is_write,
    input  logic [LEN_W-1:0] rx_len_dw,
    input  logic [AW-1:0]    rx_addr,
    input  logic [BEW-1:0]   rx_first_be,
    input  logic [RID_W-1:0] rx_req_id,
    input  logic [TAG_W-1:0] rx_tag,
    input  logic [DW-1:0]    rx_data,
    input  logic             tx_ready,
    input  logic             m_waitrequest,
    input  logic [DW-1:0]    m_readdata,
    input  logic             m_readdatavalid,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic             m_read,
    output logic             m_write,
    output req_t             req
);
    typedef struct packed {
        state_e           st;
        req_t             r;
        logic [LEN_W-1:0] left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic single;

    always_comb begin
        ctl_d  = ctl_q;
        single = (rx_len_dw == LEN_W'(1));
        case (ctl_q.st)
            ST_IDLE: begin
                if (rx_valid && rx_sop) begin
                    ctl_d.r.addr  = rx_addr;
                    ctl_d.r.be    = rx_first_be;
                    ctl_d.r.rid   = rx_req_id;
                    ctl_d.r.tag   = rx_tag;
                    ctl_d.r.data  = rx_data;
                    ctl_d.r.abort = !single;
                    ctl_d.left    = rx_len_dw - LEN_W'(1);
                    if (!rx_is_write) begin
                        ctl_d.st = single ? ST_RD_CMD : ST_CPL;
                    end else begin
                        ctl_d.st = single ? ST_WR_CMD : ST_DRAIN;
                    end
                end
            end
            ST_RD_CMD:  if (!m_waitrequest) ctl_d.st = ST_RD_DATA;
            ST_RD_DATA: begin
                if (m_readdatavalid) begin
                    ctl_d.r.data = m_readdata;
                    ctl_d.st     = ST_CPL;
                end
            end
            ST_CPL:     if (tx_ready) ctl_d.st = ST_IDLE;
            ST_WR_CMD:  if (!m_waitrequest) ctl_d.st = ST_IDLE;
            ST_DRAIN: begin
                if (rx_valid) begin
                    ctl_d.left = ctl_q.left - LEN_W'(1);
                    if (ctl_q.left == LEN_W'(1)) ctl_d.st = ST_IDLE;
                end
            end
            default:    ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rx_ready = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_DRAIN);
    assign tx_valid = (ctl_q.st == ST_CPL);
    assign m_read   = (ctl_q.st == ST_RD_CMD);
    assign m_write  = (ctl_q.st == ST_WR_CMD);
    assign req      = ctl_q.r;
endmodule

// File: rtl/sdw_completer_bridge.sv
module sdw_completer_bridge
    import sdwb_pkg::*;
#(
    parameter int            LEN_W      = 10,
    parameter int            APER_BITS  = 16,
    parameter logic [31:0]   LOCAL_BASE = 32'h4000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic             rx_sop,
    input  logic             rx_is_write,
    input  logic [LEN_W-1:0] rx_len_dw,
    input  logic [31:0]      rx_addr,
    input  logic [3:0]       rx_first_be,
    input  logic [15:0]      rx_req_id,
    input  logic [7:0]       rx_tag,
    input  logic [31:0]      rx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [2:0]       tx_status,
    output logic             tx_has_data,
    output logic [15:0]      tx_req_id,
    output logic [7:0]       tx_tag,
    output logic [11:0]      tx_byte_count,
    output logic [6:0]       tx_lower_addr,
    output logic [31:0]      tx_data,
    output logic [31:0]      m_address,
    output logic [3:0]       m_byteenable,
    output logic             m_read,
    output logic             m_write,
    output logic [31:0]      m_writedata,
    input  logic             m_waitrequest,
    input  logic [31:0]      m_readdata,
    input  logic             m_readdatavalid
);
    req_t req;

    sdwb_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_valid        (rx_valid),
        .rx_sop          (rx_sop),
        .rx_is_write     (rx_is_write),
        .rx_len_dw       (rx_len_dw),
        .rx_addr         (rx_addr),
        .rx_first_be     (rx_first_be),
        .rx_req_id       (rx_req_id),
        .rx_tag          (rx_tag),
        .rx_data         (rx_data),
        .tx_ready        (tx_ready),
        .m_waitrequest   (m_waitrequest),
        .m_readdata      (m_readdata),
        .m_readdatavalid (m_readdatavalid),
        .rx_ready        (rx_ready),
        .tx_valid        (tx_valid),
        .m_read          (m_read),
        .m_write         (m_write),
        .req             (req)
    );

    sdwb_addr_map #(.APER_BITS(APER_BITS), .LOCAL_BASE(LOCAL_BASE)) u_map (
        .pcie_addr (req.addr),
        .bus_addr  (m_address)
    );

    sdwb_be_decode u_bed (
        .be         (req.be),
        .addr_dw    (req.addr[LA_W-1:2]),
        .byte_count (tx_byte_count),
        .lower_addr (tx_lower_addr)
    );

    assign m_byteenable = req.be;
    assign m_writedata  = req.data;
    assign tx_status    = req.abort ? CPL_ABORT : CPL_OK;
    assign tx_has_data  = !req.abort;
    assign tx_req_id    = req.rid;
    assign tx_tag       = req.tag;
    assign tx_data      = req.data;
endmodule

// File: rtl/sdwb_checker.sv
module sdwb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [2:0]  tx_status,
    input logic        tx_has_data,
    input logic [15:0] tx_req_id,
    input logic [7:0]  tx_tag,
    input logic [31:0] tx_data,
    input logic        m_read,
    input logic        m_write,
    input logic        m_waitrequest,
    input logic [31:0] m_address,
    input logic [3:0]  m_byteenable
);
    assert_ready_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !(m_read || m_write || tx_valid));

    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_read && m_write));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read || m_write) && m_waitrequest |=>
            $stable(m_read) && $stable(m_write) && $stable(m_address) && $stable(m_byteenable));

    assert_cpl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=>
            tx_valid && $stable(tx_status) && $stable(tx_req_id) && $stable(tx_tag) && $stable(tx_data));

    assert_abort_nodata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && (tx_status == 3'b100) |-> !tx_has_data);

    assert_ok_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && (tx_status == 3'b000) |-> tx_has_data);
endmodule

bind sdw_completer_bridge sdwb_checker u_chk (.*);

// File: tb/sdw_completer_bridge_test.sv
module sdw_completer_bridge_test;
    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_sop = 0, rx_is_write = 0;
    logic [9:0] rx_len_dw = 0;
    logic [31:0] rx_addr = 0, rx_data = 0;
    logic [3:0] rx_first_be = 0;
    logic [15:0] rx_req_id = 0;
    logic [7:0] rx_tag = 0;
    logic rx_ready, tx_valid, tx_ready, tx_has_data;
    logic [2:0] tx_status;
    logic [15:0] tx_req_id;
    logic [7:0] tx_tag;
    logic [11:0] tx_byte_count;
    logic [6:0] tx_lower_addr;
    logic [31:0] tx_data, m_address, m_writedata, m_readdata;
    logic [3:0] m_byteenable;
    logic m_read, m_write, m_waitrequest, m_readdatavalid;

    sdw_completer_bridge uut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, fails = 0, cyc = 0;
    int wait_cfg = 0, tx_delay = 0, wcnt = 0, tcnt = 0;
    int rd_cnt = 0, wr_cnt = 0, cpl_cnt = 0;
    int last_rx_cyc = 0, cpl_cyc = 0, bus_cyc = 0;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0] bus_be;
    logic [2:0] c_status; logic c_data_f; logic [15:0] c_id; logic [7:0] c_tag;
    logic [11:0] c_bc; logic [6:0] c_la; logic [31:0] c_data;
    logic rdv_q = 0; logic [31:0] rdata_q = 0;

    assign m_waitrequest   = (m_read || m_write) && (wcnt < wait_cfg);
    assign tx_ready        = tx_valid && (tcnt >= tx_delay);
    assign m_readdatavalid = rdv_q;
    assign m_readdata      = rdata_q;

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return {a[15:0], 16'h5AC3};
    endfunction
    function automatic logic [31:0] exp_addr(input logic [31:0] a);
        return 32'h4000_0000 + (a & 32'h0000_FFFC);
    endfunction

    always @(posedge clk) begin
        cyc++;
        rdv_q <= 1'b0;
        if (rx_valid && rx_ready && rx_sop) last_rx_cyc = cyc;
        if (m_read || m_write) begin
            if (!m_waitrequest) begin
                wcnt <= 0; bus_cyc = cyc;
                bus_addr = m_address; bus_be = m_byteenable; bus_wdata = m_writedata;
                if (m_read) begin rd_cnt++; rdv_q <= 1'b1; rdata_q <= rd_model(m_address); end
                else wr_cnt++;
            end else wcnt <= wcnt + 1;
        end
        if (tx_valid) begin
            if (tx_ready) begin
                tcnt <= 0; cpl_cnt++; cpl_cyc = cyc;
                c_status = tx_status; c_data_f = tx_has_data; c_id = tx_req_id; c_tag = tx_tag;
                c_bc = tx_byte_count; c_la = tx_lower_addr; c_data = tx_data;
            end else tcnt <= tcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic send(input bit sop, input bit wr, input logic [9:0] len, input logic [31:0] a,
                        input logic [3:0] be, input logic [15:0] id, input logic [7:0] tg, input logic [31:0] d);
        rx_valid = 1; rx_sop = sop; rx_is_write = wr; rx_len_dw = len; rx_addr = a;
        rx_first_be = be; rx_req_id = id; rx_tag = tg; rx_data = d;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 0; rx_sop = 0;
    endtask

    task automatic settle();
        repeat (25) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(rx_ready == 1, "R4 reset rx_ready", 32'(rx_ready), 1);
        chk(!tx_valid && !m_read && !m_write, "R4 reset idle outputs", 32'({tx_valid, m_read, m_write}), 0);
    endtask

    task automatic t_read(input logic [31:0] a, input logic [3:0] be, input int bc, input logic [1:0] lo,
                          input int wc, input int td);
        int r0 = rd_cnt, c0 = cpl_cnt;
        wait_cfg = wc; tx_delay = td;
        send(1, 0, 10'd1, a, be, 16'hBEEF ^ 16'(a), a[7:0], 32'h0);
        settle();
        chk(rd_cnt == r0 + 1, "R1 one bus read", 32'(rd_cnt - r0), 1);
        chk(bus_addr == exp_addr(a), "R5 read address", bus_addr, exp_addr(a));
        chk(bus_be == be, "R6 read byte enables", 32'(bus_be), 32'(be));
        chk(cpl_cnt == c0 + 1 && c_status == 3'b000 && c_data_f, "R1 completion status", 32'({c_status, c_data_f}), 32'h1);
        chk(c_data == rd_model(exp_addr(a)), "R8 read data", c_data, rd_model(exp_addr(a)));
        chk(c_id == (16'hBEEF ^ 16'(a)) && c_tag == a[7:0], "R1 id/tag echo", 32'({c_id, c_tag}), 32'({16'hBEEF ^ 16'(a), a[7:0]}));
        chk(c_bc == 12'(bc), "R7 byte count", 32'(c_bc), 32'(bc));
        chk(c_la == {a[6:2], lo}, "R7 lower address", 32'(c_la), 32'({a[6:2], lo}));
    endtask

    task automatic t_big_read();
        int r0 = rd_cnt, w0 = wr_cnt, c0 = cpl_cnt;
        wait_cfg = 0; tx_delay = 1;
        send(1, 0, 10'd2, 32'h0000_0100, 4'hF, 16'h1234, 8'h77, 0);
        settle();
        chk(rd_cnt == r0 && wr_cnt == w0, "R2 no bus access", 32'(rd_cnt + wr_cnt - r0 - w0), 0);
        chk(cpl_cnt == c0 + 1 && c_status == 3'b100 && !c_data_f, "R2 abort completion", 32'({c_status, c_data_f}), 32'h8);
        chk(c_id == 16'h1234 && c_tag == 8'h77, "R2 id/tag echo", 32'({c_id, c_tag}), 32'h123477);
    endtask

    task automatic t_write(input int wc);
        int w0 = wr_cnt, c0 = cpl_cnt;
        wait_cfg = wc;
        send(1, 1, 10'd1, 32'hFEDC_1237, 4'b0011, 16'h1, 8'h2, 32'hCAFE_F00D);
        settle();
        chk(wr_cnt == w0 + 1, "R9 one bus write", 32'(wr_cnt - w0), 1);
        chk(bus_wdata == 32'hCAFE_F00D, "R9 write data", bus_wdata, 32'hCAFE_F00D);
        chk(bus_addr == 32'h4000_1234, "R5 write address", bus_addr, 32'h4000_1234);
        chk(bus_be == 4'b0011, "R6 write byte enables", 32'(bus_be), 32'h3);
        chk(cpl_cnt == c0, "R9 no completion", 32'(cpl_cnt - c0), 0);
    endtask

    task automatic t_big_write();
        int r0 = rd_cnt, w0 = wr_cnt, c0 = cpl_cnt;
        send(1, 1, 10'd3, 32'h0000_0040, 4'hF, 16'h9, 8'h9, 32'h1111_1111);
        send(1, 1, 10'd1, 32'h0000_0050, 4'hF, 16'h9, 8'h9, 32'h2222_2222);  // looks like a header, but is data
        send(0, 0, 10'd0, 32'h0, 4'h0, 16'h0, 8'h0, 32'h3333_3333);
        settle();
        chk(rd_cnt == r0 && wr_cnt == w0, "R3 no bus access", 32'(rd_cnt + wr_cnt - r0 - w0), 0);
        chk(cpl_cnt == c0, "R3 no completion", 32'(cpl_cnt - c0), 0);
        t_read(32'h0000_0088, 4'hF, 4, 2'd0, 0, 0);   // next header served normally (R3)
    endtask

    task automatic t_overlap_read();
        int cc;
        wait_cfg = 1; tx_delay = 4;
        send(1, 0, 10'd1, 32'h0000_0010, 4'hF, 16'h5, 8'h5, 0);
        send(1, 0, 10'd1, 32'h0000_0020, 4'hF, 16'h6, 8'h6, 0);
        cc = cpl_cyc;
        chk(last_rx_cyc == cc + 1, "R4 header after read completion", 32'(last_rx_cyc), 32'(cc + 1));
        settle();
    endtask

    task automatic t_overlap_write();
        wait_cfg = 3; tx_delay = 0;
        send(1, 1, 10'd1, 32'h0000_0030, 4'hF, 16'h7, 8'h7, 32'h5);
        send(1, 0, 10'd1, 32'h0000_0034, 4'hF, 16'h8, 8'h8, 0);
        chk(last_rx_cyc == bus_cyc + 1, "R4 header after bus write", 32'(last_rx_cyc), 32'(bus_cyc + 1));
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read(32'h0000_1004, 4'b1111, 4, 2'd0, 0, 0);
        t_read(32'hFEDC_5678, 4'b0110, 2, 2'd1, 3, 2);
        t_read(32'h0000_007C, 4'b1000, 1, 2'd3, 1, 0);
        t_read(32'h0000_0048, 4'b0000, 1, 2'd0, 0, 3);
        t_read(32'h0000_0060, 4'b0101, 3, 2'd0, 0, 0);
        t_big_read();
        t_write(0);
        t_write(4);
        t_big_write();
        t_overlap_read();
        t_overlap_write();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule